// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block performs the one-cycle entry into an exception or interrupt handler for a processor core. Each cycle it looks at a pending exception code, a hardware interrupt request with its controller-supplied vector, and the core's current status word, program counter, stack register (general register 15) and vector base. It then picks at most one event and, on the next clock edge, produces the updated status word, the new program counter, the saved copies of the old state, the recorded event code and a one-cycle `taken_o` strobe.

Event inputs are level requests sampled every cycle. The block never stalls: an entry always finishes in one cycle. It therefore has no ready signal and no back-pressure. When nothing is taken, the registered status and program counter outputs simply take on the core's presented values on the next edge, and the shadow and event registers keep their contents.

The current interrupt mask is passed combinationally to the interrupt controller. The controller answers with a vector and a flag that is low when every pending source is masked.

Top module: `evt_entry_seq`

## Requirements
- R1: When an exception and an interrupt are pending in the same cycle, the exception is taken and the interrupt event register keeps its value.
- R2: With the block bit (status bit 28) set, an exception with any code other than 0x1E0 is entered as code 0x000 with reset handling. Code 0x1E0 keeps its code and uses the general vector.
- R3: With status bit 28 set, an interrupt request alone produces no entry: `taken_o` stays low and the status and program counter outputs follow the core's inputs.
- R4: `irq_mask_o` always equals status bits 7:4. An interrupt request whose vector-valid flag is low produces no entry.
- R5: On any entry, `ssr_o` receives the pre-entry status word and `sgr_o` receives the pre-entry register 15. `spc_o` receives the pre-entry program counter, plus 2 for exception code 0x160 only.
- R6: On any entry, the new status word has bits 28 (block), 29 (bank) and 30 (privileged) set, and keeps every other bit except those changed under R7.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set bits 7:4 to 0xF and load the program counter with 0xA0000000.
- R8: Exception codes 0x040 and 0x060 load the program counter with the vector base plus 0x400.
- R9: Code 0x160 and every exception code not named in R7 or R8 load the program counter with the vector base plus 0x100.
- R10: An exception entry writes the (possibly substituted) code into `expevt_o`. An interrupt entry writes the vector into `intevt_o` and loads the program counter with the vector base plus 0x600. The other event register is unchanged.
- R11: All updates of one entry appear on the same edge as the `taken_o` pulse. Without an entry, `sr_o` and `pc_o` take `sr_i` and `pc_i` on the next edge, and the shadow and event registers hold their values.
- R12: Synchronous reset sets `sr_o` to 0x50000000 (privileged, blocked), `pc_o` to 0xA0000000, and clears `taken_o` and all shadow and event registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_vld_i | input | 1 | Exception pending |
| exc_code_i | input | 12 | Pending exception code |
| irq_req_i | input | 1 | Hardware interrupt request |
| irq_vec_vld_i | input | 1 | Controller has an unmasked vector |
| irq_vec_i | input | 12 | Interrupt vector code from controller |
| irq_mask_o | output | 4 | Current interrupt mask to controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current general register 15 |
| vbr_i | input | 32 | Vector base |
| taken_o | output | 1 | Entry performed on this edge |
| sr_o | output | 32 | Updated status word |
| pc_o | output | 32 | Updated program counter |
| ssr_o | output | 32 | Saved status word |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved register 15 |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |

## Verification
The first sweep walks every 32-byte-aligned exception code, with the block bit clear and set, and with and without a simultaneous interrupt. This separates the reset, miss, trap and general vector classes, the 0x1E0 exemption and exception priority. The second sweep walks all sixteen mask values against vector-valid and the block bit, which tells a masked or blocked request apart from a real interrupt entry. Idle cycles with changing core state between entries show the pass-through of status and program counter and the holding of the shadow registers.

// File: rtl/evt_entry_pkg.sv
package evt_entry_pkg;
  localparam int EVT_W     = 12;
  localparam int SR_IM_LSB = 4;
  localparam int SR_IM_W   = 4;
  localparam int SR_FD_BIT = 15;
  localparam int SR_BL_BIT = 28;
  localparam int SR_RB_BIT = 29;
  localparam int SR_MD_BIT = 30;

  localparam logic [EVT_W-1:0] CODE_RESET   = 12'h000;
  localparam logic [EVT_W-1:0] CODE_MANRST  = 12'h020;
  localparam logic [EVT_W-1:0] CODE_TLBMUL  = 12'h140;
  localparam logic [EVT_W-1:0] CODE_TLBRD   = 12'h040;
  localparam logic [EVT_W-1:0] CODE_TLBWR   = 12'h060;
  localparam logic [EVT_W-1:0] CODE_TRAP    = 12'h160;
  localparam logic [EVT_W-1:0] CODE_BLSAFE  = 12'h1E0;

  typedef enum logic [1:0] {EK_NONE, EK_EXC, EK_IRQ} evt_kind_e;
  typedef enum logic [1:0] {VC_RESET, VC_TLBMISS, VC_GENERAL, VC_IRQ} vec_class_e;
endpackage

// File: rtl/evt_select.sv
module evt_select
  import evt_entry_pkg::*;
(
  input  logic             exc_vld_i,
  input  logic [EVT_W-1:0] exc_code_i,
  input  logic             irq_req_i,
  input  logic             irq_vec_vld_i,
  input  logic [EVT_W-1:0] irq_vec_i,
  input  logic             bl_i,
  output evt_kind_e        kind_o,
  output logic [EVT_W-1:0] code_o
);
  // Exception wins; blocked state turns most exceptions into reset and drops interrupts.
  always_comb begin
    kind_o = EK_NONE;
    code_o = '0;
    if (exc_vld_i) begin
      kind_o = EK_EXC;
      code_o = (bl_i && (exc_code_i != CODE_BLSAFE)) ? CODE_RESET : exc_code_i;
    end else if (irq_req_i && irq_vec_vld_i && !bl_i) begin
      kind_o = EK_IRQ;
      code_o = irq_vec_i;
    end
  end
endmodule

// File: rtl/evt_target.sv
module evt_target
  import evt_entry_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter logic [XLEN-1:0]  RESET_PC  = 32'hA000_0000,
  parameter logic [XLEN-1:0]  OFS_GEN   = 32'h0000_0100,
  parameter logic [XLEN-1:0]  OFS_TLB   = 32'h0000_0400,
  parameter logic [XLEN-1:0]  OFS_IRQ   = 32'h0000_0600,
  parameter logic [XLEN-1:0]  TRAP_ADJ  = 32'd2
) (
  input  evt_kind_e        kind_i,
  input  logic [EVT_W-1:0] code_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic [XLEN-1:0]  sr_n_o,
  output logic [XLEN-1:0]  pc_n_o,
  output logic [XLEN-1:0]  spc_n_o
);
  localparam logic [XLEN-1:0] ENTRY_SET =
    (XLEN'(1) << SR_BL_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_MD_BIT);
  localparam logic [XLEN-1:0] IM_FIELD = XLEN'(((1 << SR_IM_W) - 1) << SR_IM_LSB);
  localparam logic [XLEN-1:0] FD_MASK  = XLEN'(1) << SR_FD_BIT;

  vec_class_e vclass;

  always_comb begin
    if (kind_i == EK_IRQ) vclass = VC_IRQ;
    else begin
      unique case (code_i)
        CODE_RESET, CODE_MANRST, CODE_TLBMUL: vclass = VC_RESET;
        CODE_TLBRD, CODE_TLBWR:               vclass = VC_TLBMISS;
        default:                              vclass = VC_GENERAL;
      endcase
    end
  end

  always_comb begin
    sr_n_o = sr_i | ENTRY_SET;
    unique case (vclass)
      VC_RESET: begin
        sr_n_o = (sr_n_o & ~FD_MASK) | IM_FIELD;
        pc_n_o = RESET_PC;
      end
      VC_TLBMISS: pc_n_o = vbr_i + OFS_TLB;
      VC_IRQ:     pc_n_o = vbr_i + OFS_IRQ;
      default:    pc_n_o = vbr_i + OFS_GEN;
    endcase
  end

  always_comb begin
    spc_n_o = pc_i;
    if (kind_i == EK_EXC && code_i == CODE_TRAP) spc_n_o = pc_i + TRAP_ADJ;
  end
endmodule

// File: rtl/evt_entry_seq.sv
module evt_entry_seq
  import evt_entry_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0]  OFS_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0]  OFS_TLB  = 32'h0000_0400,
  parameter logic [XLEN-1:0]  OFS_IRQ  = 32'h0000_0600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_vld_i,
  input  logic [EVT_W-1:0] exc_code_i,
  input  logic             irq_req_i,
  input  logic             irq_vec_vld_i,
  input  logic [EVT_W-1:0] irq_vec_i,
  output logic [SR_IM_W-1:0] irq_mask_o,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  r15_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic             taken_o,
  output logic [XLEN-1:0]  sr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  ssr_o,
  output logic [XLEN-1:0]  spc_o,
  output logic [XLEN-1:0]  sgr_o,
  output logic [EVT_W-1:0] expevt_o,
  output logic [EVT_W-1:0] intevt_o
);
  localparam logic [XLEN-1:0] RESET_SR = (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_BL_BIT);

  evt_kind_e        kind;
  logic [EVT_W-1:0] code;
  logic [XLEN-1:0]  sr_n, pc_n, spc_n;

  assign irq_mask_o = sr_i[SR_IM_LSB +: SR_IM_W];

  evt_select u_sel (
    .exc_vld_i     (exc_vld_i),
    .exc_code_i    (exc_code_i),
    .irq_req_i     (irq_req_i),
    .irq_vec_vld_i (irq_vec_vld_i),
    .irq_vec_i     (irq_vec_i),
    .bl_i          (sr_i[SR_BL_BIT]),
    .kind_o        (kind),
    .code_o        (code)
  );

  evt_target #(
    .XLEN(XLEN), .RESET_PC(RESET_PC), .OFS_GEN(OFS_GEN),
    .OFS_TLB(OFS_TLB), .OFS_IRQ(OFS_IRQ), .TRAP_ADJ(XLEN'(2))
  ) u_tgt (
    .kind_i  (kind),
    .code_i  (code),
    .sr_i    (sr_i),
    .pc_i    (pc_i),
    .vbr_i   (vbr_i),
    .sr_n_o  (sr_n),
    .pc_n_o  (pc_n),
    .spc_n_o (spc_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o  <= 1'b0;
      sr_o     <= RESET_SR;
      pc_o     <= RESET_PC;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
    end else if (kind == EK_NONE) begin
      taken_o <= 1'b0;
      sr_o    <= sr_i;
      pc_o    <= pc_i;
    end else begin
      taken_o <= 1'b1;
      sr_o    <= sr_n;
      pc_o    <= pc_n;
      ssr_o   <= sr_i;
      spc_o   <= spc_n;
      sgr_o   <= r15_i;
      if (kind == EK_EXC) expevt_o <= code;
      else                intevt_o <= code;
    end
  end

  // R5
  saved_sr_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (ssr_o == $past(sr_i) && sgr_o == $past(r15_i)));

  // R6
  entry_bits_chk: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));

  // R11
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> ($stable(ssr_o) && $stable(spc_o) && $stable(sgr_o)));

  // R3
  blocked_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && $past(sr_i[SR_BL_BIT])) |-> $past(exc_vld_i));

  // R10
  irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (taken_o && !$past(exc_vld_i)) |-> (pc_o == $past(vbr_i) + OFS_IRQ && $stable(expevt_o)));
endmodule

// File: tb/sim_evt_entry_seq.sv
`timescale 1ns/1ps
module sim_evt_entry_seq;
  logic clk = 0, rst = 1;
  logic exc_vld = 0, irq_req = 0, vec_vld = 0;
  logic [11:0] exc_code = 0, irq_vec = 0, expevt, intevt;
  logic [3:0]  imask;
  logic [31:0] sr = 0, pc = 0, r15 = 0, vbr = 0;
  logic        taken;
  logic [31:0] sr_q, pc_q, ssr_q, spc_q, sgr_q;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] e_ssr = 0, e_spc = 0, e_sgr = 0;
  logic [11:0] e_exp = 0, e_int = 0;

  always #4 clk = ~clk;

  evt_entry_seq u0 (
    .clk(clk), .rst(rst), .exc_vld_i(exc_vld), .exc_code_i(exc_code),
    .irq_req_i(irq_req), .irq_vec_vld_i(vec_vld), .irq_vec_i(irq_vec),
    .irq_mask_o(imask), .sr_i(sr), .pc_i(pc), .r15_i(r15), .vbr_i(vbr),
    .taken_o(taken), .sr_o(sr_q), .pc_o(pc_q), .ssr_o(ssr_q), .spc_o(spc_q),
    .sgr_o(sgr_q), .expevt_o(expevt), .intevt_o(intevt)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Applies one cycle of stimulus at a negedge, checks after the next posedge.
  task automatic step(input bit ev, input logic [11:0] code, input bit irq, input bit vv,
                      input logic [11:0] vec, input logic [31:0] s, input logic [31:0] p,
                      input logic [31:0] g, input logic [31:0] b, input string tag);
    int tk;
    logic [11:0] c;
    logic [31:0] x_sr, x_pc;
    exc_vld = ev; exc_code = code; irq_req = irq; vec_vld = vv; irq_vec = vec;
    sr = s; pc = p; r15 = g; vbr = b;
    tk = 0; c = 0;
    if (ev) begin tk = 1; c = (s[28] && code != 12'h1E0) ? 12'h000 : code; end
    else if (irq && vv && !s[28]) begin tk = 2; c = vec; end
    x_sr = s; x_pc = p;
    if (tk != 0) begin
      e_ssr = s; e_sgr = g;
      e_spc = p + ((tk == 1 && c == 12'h160) ? 32'd2 : 32'd0);
      x_sr = s | 32'h7000_0000;
      if (tk == 2) begin e_int = c; x_pc = b + 32'h600; end
      else begin
        e_exp = c;
        if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
          x_sr = (x_sr & ~32'h0000_8000) | 32'h0000_00F0; x_pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) x_pc = b + 32'h400;
        else x_pc = b + 32'h100;
      end
    end
    #1;
    chk(imask == s[7:4], "R4", 64'(imask), 64'(s[7:4]));
    @(posedge clk); @(negedge clk);
    chk(taken == (tk != 0), tag, 64'(taken), 64'(tk != 0));
    chk(pc_q == x_pc, tag, 64'(pc_q), 64'(x_pc));
    chk(sr_q == x_sr, (tk != 0) ? "R6" : "R11", 64'(sr_q), 64'(x_sr));
    chk({ssr_q, spc_q} == {e_ssr, e_spc} && sgr_q == e_sgr, "R5", {ssr_q, spc_q}, {e_ssr, e_spc});
    chk(expevt == e_exp && intevt == e_int, "R10", {40'd0, expevt, intevt}, {40'd0, e_exp, e_int});
  endtask

  function automatic string exc_tag(input logic [11:0] c, input bit bl, input bit irq);
    if (bl && c != 12'h1E0) return "R2";
    if (irq) return "R1";
    if (c == 12'h000 || c == 12'h020 || c == 12'h140) return "R7";
    if (c == 12'h040 || c == 12'h060) return "R8";
    return "R9";
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(sr_q == 32'h5000_0000, "R12", 64'(sr_q), 64'h5000_0000);
    chk(pc_q == 32'hA000_0000, "R12", 64'(pc_q), 64'hA000_0000);
    chk(!taken && ssr_q == 0 && spc_q == 0 && sgr_q == 0 && expevt == 0 && intevt == 0,
        "R12", 64'(taken), 64'd0);
    rst = 0;
    // Exception sweep: all aligned codes x blocked x concurrent interrupt
    for (int i = 0; i < 128; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] s;
        logic [11:0] c;
        c = 12'(i * 32);
        s = ((32'h0000_8A5C ^ (32'(i) * 32'h0101_0013)) & ~32'h1000_0000) | (32'(m & 1) << 28);
        step(1'b1, c, m[1], 1'b1, 12'h5A0, s, 32'h0C00_0000 + 32'(i * 6),
             32'h1234_0000 ^ 32'(i), 32'h8C00_0000 + 32'(i) * 32'h100, exc_tag(c, m[0], m[1]));
        // idle cycle: pass-through and hold (R11)
        step(1'b0, 12'h0, 1'b0, 1'b0, 12'h0, s ^ 32'h0000_0300, 32'h0D00_0000 + 32'(i),
             32'hFFFF_0000, 32'h0, "R11");
      end
    end
    // Interrupt sweep: every mask x vector-valid x blocked
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] s;
        s = 32'h0000_0001 | (32'(m) << 4) | (32'(k >> 1) << 28);
        step(1'b0, 12'h0, 1'b1, k[0], 12'h200 + 12'(m * 32), s, 32'h0E00_0000 + 32'(m * 4),
             32'hABCD_0000 + 32'(k), 32'h9000_0000 + 32'(m) * 32'h1000,
             (k >> 1) != 0 ? "R3" : (k[0] ? "R10" : "R4"));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule